// File: doc/BRIEF.md
# General-Purpose Input Event Status and Routing

This block watches a bank of general-purpose input pins and turns activity on them into sticky event status for two separate interrupt paths: one that feeds the system-control interrupt and one that feeds the system-management interrupt. Each pin is first brought into the clock domain through a two-stage synchronizer. A per-pin polarity bit then decides whether the pin is active-high or active-low. A per-pin select bit can hand the pin to an alternate function, and a pin handed over in this way takes no further part in event detection.

Both paths see every active input. Each path holds its own status bits, which software clears by writing 1, and its own enable bits. The interrupt output of a path is a registered OR over all inputs of status AND enable. The two paths place the same input at different bit positions. The control-interrupt path places input i at bit 16+i of its status and enable words. The management path places input i at bit i.

Software reaches the block through a simple word-addressed register port. Writes take effect at the clock edge. Reads return registered data one cycle after the address is presented.

Top module: `gpi_evt_router`

## Requirements
- R1: After synchronous reset, every register reads 0, and both `sci_irq` and `smi_irq` are low.
- R2: Event-status word (address 0) and event-enable word (address 1) hold input i at bit 16+i, and their bits 15:0 always read 0.
- R3: Alternate-status word (address 2) and alternate-enable word (address 3) hold input i at bit i, and their bits 31:16 always read 0.
- R4: The polarity word (address 4) bit i set to 1 makes input i active when the pin is low; 0 makes it active when high.
- R5: While bit i of the select word (address 5) is 1, input i never sets a status bit in either path, whatever the pin does.
- R6: A status bit stays set until software writes 1 to its position; writing 0 has no effect, and clearing one path's bit leaves the other path's bit unchanged.
- R7: If the input is still active when its status bit is cleared, the bit reads 1 again (set wins over clear).
- R8: `sci_irq` equals the OR of (event status AND event enable) one clock after the status value, and `smi_irq` does the same for the alternate status and enable.
- R9: A pin change sets status on the third rising edge after it, and the interrupt output follows on the fourth rising edge.
- R10: The polarity and select words hold input i at bit i; upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpi_pin | input | N_IN | Asynchronous general-purpose input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| sci_irq | output | 1 | Control-interrupt path request |
| smi_irq | output | 1 | Management-interrupt path request |

## Verification
The assertions check on every cycle several properties. Each interrupt output follows the enabled status of its path with a one-cycle lag. No status bit rises for a pin that was taken by its alternate function. No status bit drops without a matching write-1 clear. The unused low half of the event words reads zero. The scenarios alone can show the rest: the bit mapping of each input in both paths, the polarity inversion, the exact synchronizer latency, and that a clear loses to a still-active input. The scenarios also show that the two paths clear independently.

// File: rtl/gpi_evt_pkg.sv
package gpi_evt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_GPE_STS = 3'd0,
    RA_GPE_EN  = 3'd1,
    RA_ALT_STS = 3'd2,
    RA_ALT_EN  = 3'd3,
    RA_INV     = 3'd4,
    RA_SEL     = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpi_evt_sync.sv
module gpi_evt_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpi_evt_sts_bank.sv
module gpi_evt_sts_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             sts[i] <= 1'b0;
      else if (set_vec[i]) sts[i] <= 1'b1;
      else if (clr_vec[i]) sts[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpi_evt_irq.sv
module gpi_evt_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sts,
  input  logic [W-1:0] en,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts & en);
  end
endmodule

// File: rtl/gpi_evt_router.sv
module gpi_evt_router
  import gpi_evt_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int DATA_W  = 32,
  parameter int GPE_LSB = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   gpi_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sci_irq,
  output logic              smi_irq
);
  logic [N_IN-1:0] gpe_en, alt_en, inv, sel;
  logic [N_IN-1:0] pin_s, act;
  logic [N_IN-1:0] gpe_clr, alt_clr;
  logic [N_IN-1:0] gpe_sts, alt_sts;
  logic [DATA_W-1:0] rd_nxt;

  // configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      gpe_en <= '0;
      alt_en <= '0;
      inv    <= '0;
      sel    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_GPE_EN: gpe_en <= reg_wdata[GPE_LSB +: N_IN];
        RA_ALT_EN: alt_en <= reg_wdata[N_IN-1:0];
        RA_INV:    inv    <= reg_wdata[N_IN-1:0];
        RA_SEL:    sel    <= reg_wdata[N_IN-1:0];
        default: ;
      endcase
    end
  end

  gpi_evt_sync #(.W(N_IN), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(gpi_pin), .dout(pin_s)
  );

  // polarity then alternate-function mask
  assign act = (pin_s ^ inv) & ~sel;

  assign gpe_clr = (reg_we && reg_addr == RA_GPE_STS) ? reg_wdata[GPE_LSB +: N_IN] : '0;
  assign alt_clr = (reg_we && reg_addr == RA_ALT_STS) ? reg_wdata[N_IN-1:0] : '0;

  gpi_evt_sts_bank #(.W(N_IN)) u_gpe_bank (
    .clk(clk), .rst(rst), .set_vec(act), .clr_vec(gpe_clr), .sts(gpe_sts)
  );

  gpi_evt_sts_bank #(.W(N_IN)) u_alt_bank (
    .clk(clk), .rst(rst), .set_vec(act), .clr_vec(alt_clr), .sts(alt_sts)
  );

  gpi_evt_irq #(.W(N_IN)) u_sci (
    .clk(clk), .rst(rst), .sts(gpe_sts), .en(gpe_en), .irq(sci_irq)
  );

  gpi_evt_irq #(.W(N_IN)) u_smi (
    .clk(clk), .rst(rst), .sts(alt_sts), .en(alt_en), .irq(smi_irq)
  );

  // read mux, registered
  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      RA_GPE_STS: rd_nxt[GPE_LSB +: N_IN] = gpe_sts;
      RA_GPE_EN:  rd_nxt[GPE_LSB +: N_IN] = gpe_en;
      RA_ALT_STS: rd_nxt[N_IN-1:0]        = alt_sts;
      RA_ALT_EN:  rd_nxt[N_IN-1:0]        = alt_en;
      RA_INV:     rd_nxt[N_IN-1:0]        = inv;
      RA_SEL:     rd_nxt[N_IN-1:0]        = sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/gpi_evt_router_chk.sv
module gpi_evt_router_chk
  import gpi_evt_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int DATA_W  = 32,
  parameter int GPE_LSB = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sci_irq,
  input logic              smi_irq,
  input logic [N_IN-1:0]   gpe_sts,
  input logic [N_IN-1:0]   alt_sts,
  input logic [N_IN-1:0]   gpe_en,
  input logic [N_IN-1:0]   alt_en,
  input logic [N_IN-1:0]   sel
);
  logic [N_IN-1:0] w_gpe, w_alt;
  assign w_gpe = (reg_we && reg_addr == RA_GPE_STS) ? reg_wdata[GPE_LSB +: N_IN] : '0;
  assign w_alt = (reg_we && reg_addr == RA_ALT_STS) ? reg_wdata[N_IN-1:0] : '0;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sci_irq && !smi_irq && gpe_sts == '0 && alt_sts == '0));

  assert_sci_follow_R8: assert property (@(posedge clk) disable iff (rst)
    sci_irq == $past(|(gpe_sts & gpe_en)));

  assert_smi_follow_R8: assert property (@(posedge clk) disable iff (rst)
    smi_irq == $past(|(alt_sts & alt_en)));

  assert_sel_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((gpe_sts & ~$past(gpe_sts)) | (alt_sts & ~$past(alt_sts))) & $past(sel)) == '0);

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(gpe_sts) & ~gpe_sts) & ~$past(w_gpe)) == '0 &&
                     (($past(alt_sts) & ~alt_sts) & ~$past(w_alt)) == '0));

  assert_low_half_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(reg_addr) == RA_GPE_STS || $past(reg_addr) == RA_GPE_EN))
      |-> reg_rdata[GPE_LSB-1:0] == '0);
endmodule

bind gpi_evt_router gpi_evt_router_chk #(.N_IN(N_IN), .DATA_W(DATA_W), .GPE_LSB(GPE_LSB)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .sci_irq(sci_irq), .smi_irq(smi_irq),
  .gpe_sts(gpe_sts), .alt_sts(alt_sts), .gpe_en(gpe_en), .alt_en(alt_en), .sel(sel)
);

// File: tb/gpi_evt_router_bench.sv
`timescale 1ns/1ps
module gpi_evt_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] gpi_pin = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sci_irq, smi_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpi_evt_router u_gpi_evt_router (
    .clk(clk), .rst(rst), .gpi_pin(gpi_pin), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci_irq(sci_irq), .smi_irq(smi_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clean();
    gpi_pin = '0;
    wr(3'd4, '0);
    wr(3'd5, '0);
    wait_cyc(4);
    wr(3'd0, '1);
    wr(3'd2, '1);
    wr(3'd1, '0);
    wr(3'd3, '0);
    wait_cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 sci after reset", {31'b0, sci_irq}, 32'h0);
    chk("R1 smi after reset", {31'b0, smi_irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R2 event enable mapping", d, 32'hFFFF_0000);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R3 alt enable mapping", d, 32'h0000_FFFF);
    wr(3'd4, 32'h1234_5678); rd(3'd4, d); chk("R10 polarity mapping", d, 32'h0000_5678);
    wr(3'd5, 32'hABCD_9ABC); rd(3'd5, d); chk("R10 select mapping", d, 32'h0000_9ABC);
    clean();
  endtask

  task automatic t_map();
    logic [31:0] d;
    gpi_pin = 16'h8005;
    wait_cyc(5);
    rd(3'd0, d); chk("R2 event status input i at bit 16+i", d, 32'h8005_0000);
    rd(3'd2, d); chk("R3 alt status input i at bit i", d, 32'h0000_8005);
    clean();
  endtask

  task automatic t_latency();
    wr(3'd1, 32'h0008_0000);
    @(negedge clk);
    gpi_pin[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 no irq after three edges", {31'b0, sci_irq}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 irq on fourth edge", {31'b0, sci_irq}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    // input 3 still high from t_latency
    wr(3'd0, 32'h0008_0000);
    rd(3'd0, d); chk("R7 clear loses to active input", d, 32'h0008_0000);
    gpi_pin[3] = 1'b0;
    wait_cyc(4);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d); chk("R6 write 0 keeps status", d, 32'h0008_0000);
    wr(3'd0, 32'h0008_0000);
    rd(3'd0, d); chk("R6 write 1 clears status", d, 32'h0);
    rd(3'd2, d); chk("R6 other path untouched", d, 32'h0000_0008);
    wait_cyc(1);
    chk("R8 sci drops after clear", {31'b0, sci_irq}, 32'h0);
    clean();
  endtask

  task automatic t_inv();
    logic [31:0] d;
    wr(3'd4, 32'h0000_0020);
    wait_cyc(4);
    rd(3'd0, d); chk("R4 inverted low pin is active", d, 32'h0020_0000);
    gpi_pin[5] = 1'b1;
    wait_cyc(4);
    wr(3'd0, '1);
    wr(3'd2, '1);
    wait_cyc(4);
    rd(3'd0, d); chk("R4 inverted high pin is idle", d, 32'h0);
    clean();
  endtask

  task automatic t_sel();
    logic [31:0] d;
    wr(3'd1, 32'h0080_0000);
    wr(3'd3, 32'h0000_0080);
    wr(3'd5, 32'h0000_0080);
    gpi_pin[7] = 1'b1;
    wait_cyc(6);
    rd(3'd0, d); chk("R5 selected pin no event status", d, 32'h0);
    rd(3'd2, d); chk("R5 selected pin no alt status", d, 32'h0);
    chk("R5 no sci from selected pin", {31'b0, sci_irq}, 32'h0);
    chk("R5 no smi from selected pin", {31'b0, smi_irq}, 32'h0);
    wr(3'd5, 32'h0);
    wait_cyc(3);
    rd(3'd2, d); chk("R5 released pin sets status", d, 32'h0000_0080);
    clean();
  endtask

  task automatic t_irq();
    wr(3'd1, 32'h0002_0000);
    wr(3'd3, 32'h0000_0004);
    gpi_pin[1] = 1'b1;
    wait_cyc(5);
    chk("R8 sci from enabled event", {31'b0, sci_irq}, 32'h1);
    chk("R8 smi masked by alt enable", {31'b0, smi_irq}, 32'h0);
    gpi_pin[2] = 1'b1;
    wait_cyc(5);
    chk("R8 smi from enabled alt status", {31'b0, smi_irq}, 32'h1);
    wr(3'd1, 32'h0);
    wait_cyc(1);
    chk("R8 sci drops when enable cleared", {31'b0, sci_irq}, 32'h0);
    clean();
    chk("R8 smi low after clean", {31'b0, smi_irq}, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_map();
    t_latency();
    t_clear();
    t_inv();
    t_sel();
    t_irq();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule